// File: doc/BRIEF.md
# Write-Back Write-Allocate Line Cache

This block is a small fully associative data cache. It sits between a processor port and a slower memory port. The processor side carries byte loads and stores, and each access is a request held until the cache raises ready. The memory side moves whole lines: it reads a line on a fill and writes a line back when a modified line is evicted. Each line stores a valid flag, a modified ("dirty") flag, a tag and a block of words.

Stores that hit change only the cached copy and set the line's dirty flag. Stores that miss first bring the line in from memory and then merge the byte into it. Memory is written only when a dirty line is chosen as a victim, and that write happens before the fill that reuses the line. The victim is a free line if one exists; otherwise it is the least recently used line. Two saturating counters record how many completed accesses hit and how many missed.

Top module: `wbwa_cache`

## Requirements
- R1: After reset, cpu_ready and mem_valid are low, both counters read zero, and every line is invalid, so the first access to any address misses.
- R2: An access that hits raises cpu_ready in the second cycle of the request (the cycle after the cache sees cpu_valid), with no memory request. A load's byte appears on cpu_rdata in that same cycle. Address bit 0 selects the word within the line.
- R3: A miss issues a read request with mem_valid=1, mem_we=0 and mem_addr equal to the address bits above the word offset (the tag). The returned line packs word 0 in the low DATA_W bits. cpu_ready rises in the cycle after the read is accepted, and a load returns the filled byte.
- R4: A store that hits sends nothing to memory. A later load of that byte returns the stored value.
- R5: A store that misses fetches the line first and then merges the byte. A later load of the other word returns the memory value, and a load of the stored word returns the store data.
- R6: When the victim line is dirty, a write request (mem_valid=1, mem_we=1, mem_addr = the victim's tag, mem_wline = its data) is completed before the read request for the new line.
- R7: A victim line that is clean is dropped without any memory write. The first memory request of that miss is a read.
- R8: Victim choice uses an invalid line while one exists. Once all lines are valid, it picks the line whose last completed access is the oldest.
- R9: cpu_ready stays low while a miss is being serviced. mem_valid, mem_we and mem_addr stay stable until mem_ready is seen.
- R10: Each completed access increments exactly one counter: hit_cnt if no memory read was needed, miss_cnt otherwise. Both counters saturate at all ones.
- R11: A line that was written back and later refilled is clean. Evicting it again without a store produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_valid | input | 1 | Processor request; held with stable fields until cpu_ready |
| cpu_ready | output | 1 | Access completes in this cycle |
| cpu_we | input | 1 | 1 = store byte, 0 = load byte |
| cpu_addr | input | ADDR_W | Byte address: tag above, word offset in low OFF_W bits |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid while cpu_ready is high |
| mem_valid | output | 1 | Memory line request |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W-OFF_W | Line address (tag) |
| mem_wline | output | DATA_W*2^OFF_W | Line data for write-back |
| mem_rline | input | DATA_W*2^OFF_W | Line data returned by a read, sampled with mem_ready |
| hit_cnt | output | CNT_W | Saturating count of completed hits |
| miss_cnt | output | CNT_W | Saturating count of completed misses |

## Verification
The cache is driven with loads and stores that hit. It is also driven with misses that land in a free line, misses that evict a clean line, and misses that evict a dirty line. Together these separate silent cache updates, plain fills, dropped victims and write-back-then-fill sequences. Access orders are arranged so that the least recently used line differs from the least recently filled one, which exposes a wrong victim choice. Memory latencies of zero and several cycles show whether requests are held and whether the processor port stays stalled. Long runs of repeated hits and of alternating misses drive both counters into saturation.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_WBACK  = 2'd2,
    ST_FILL   = 2'd3
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_match.sv
module wbc_tag_match #(
  parameter int LINES = 2,
  parameter int TAG_W = 3,
  parameter int IDX_W = 1
) (
  input  logic [LINES-1:0]       vld,
  input  logic [LINES*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]       key,
  output logic                   hit,
  output logic [IDX_W-1:0]       idx
);
  logic [LINES-1:0] match;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g*TAG_W +: TAG_W] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/wbc_victim_sel.sv
module wbc_victim_sel #(
  parameter int LINES = 2,
  parameter int IDX_W = 1
) (
  input  logic [LINES-1:0]       vld,
  input  logic [LINES*IDX_W-1:0] ranks,
  output logic [IDX_W-1:0]       idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(LINES - 1);

  logic found;

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (!vld[i] && !found) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < LINES; i++) begin
        if (ranks[i*IDX_W +: IDX_W] == OLDEST) idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wbc_sat_counter.sv
module wbc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (inc && (cnt != '1)) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/wbwa_cache.sv
module wbwa_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  parameter int LINES  = 2,
  parameter int CNT_W  = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cpu_valid,
  output logic                                 cpu_ready,
  input  logic                                 cpu_we,
  input  logic [ADDR_W-1:0]                    cpu_addr,
  input  logic [DATA_W-1:0]                    cpu_wdata,
  output logic [DATA_W-1:0]                    cpu_rdata,
  output logic                                 mem_valid,
  input  logic                                 mem_ready,
  output logic                                 mem_we,
  output logic [ADDR_W-OFF_W-1:0]              mem_addr,
  output logic [DATA_W*(2**OFF_W)-1:0]         mem_wline,
  input  logic [DATA_W*(2**OFF_W)-1:0]         mem_rline,
  output logic [CNT_W-1:0]                     hit_cnt,
  output logic [CNT_W-1:0]                     miss_cnt
);
  localparam int WORDS  = 2 ** OFF_W;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // line storage
  logic [LINES-1:0]  vld_q, vld_d, dty_q, dty_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [TAG_W-1:0]  tag_d  [LINES];
  logic [LINE_W-1:0] dat_q  [LINES];
  logic [LINE_W-1:0] dat_d  [LINES];
  logic [IDX_W-1:0]  rank_q [LINES];
  logic [IDX_W-1:0]  rank_d [LINES];

  wbc_state_e       state_q, state_d;
  logic [IDX_W-1:0] vict_q, vict_d;
  logic             missed_q, missed_d;

  logic [TAG_W-1:0]       req_tag;
  logic [OFF_W-1:0]       req_off;
  logic [LINES*TAG_W-1:0] tags_flat;
  logic [LINES*IDX_W-1:0] ranks_flat;
  logic                   hit;
  logic [IDX_W-1:0]       hit_idx;
  logic [IDX_W-1:0]       vict_idx;
  logic [LINE_W-1:0]      hit_line;
  logic                   inc_hit, inc_miss;

  assign req_tag = cpu_addr[ADDR_W-1:OFF_W];
  assign req_off = cpu_addr[OFF_W-1:0];

  for (genvar g = 0; g < LINES; g++) begin : g_flat
    assign tags_flat[g*TAG_W +: TAG_W]  = tag_q[g];
    assign ranks_flat[g*IDX_W +: IDX_W] = rank_q[g];
  end

  wbc_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .vld  (vld_q),
    .tags (tags_flat),
    .key  (req_tag),
    .hit  (hit),
    .idx  (hit_idx)
  );

  wbc_victim_sel #(.LINES(LINES), .IDX_W(IDX_W)) u_victim (
    .vld   (vld_q),
    .ranks (ranks_flat),
    .idx   (vict_idx)
  );

  assign hit_line  = dat_q[hit_idx];
  assign cpu_rdata = hit_line[req_off*DATA_W +: DATA_W];
  assign mem_wline = dat_q[vict_q];

  // next-state logic
  always_comb begin
    state_d   = state_q;
    vict_d    = vict_q;
    missed_d  = missed_q;
    vld_d     = vld_q;
    dty_d     = dty_q;
    tag_d     = tag_q;
    dat_d     = dat_q;
    rank_d    = rank_q;
    cpu_ready = 1'b0;
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = req_tag;
    inc_hit   = 1'b0;
    inc_miss  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        missed_d = 1'b0;
        if (cpu_valid) state_d = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (hit) begin
          cpu_ready = 1'b1;
          inc_hit   = !missed_q;
          inc_miss  = missed_q;
          if (cpu_we) begin
            dat_d[hit_idx][req_off*DATA_W +: DATA_W] = cpu_wdata;
            dty_d[hit_idx] = 1'b1;
          end
          for (int j = 0; j < LINES; j++) begin
            if (rank_q[j] < rank_q[hit_idx]) rank_d[j] = rank_q[j] + 1'b1;
          end
          rank_d[hit_idx] = '0;
          state_d = ST_IDLE;
        end else begin
          missed_d = 1'b1;
          vict_d   = vict_idx;
          if (vld_q[vict_idx] && dty_q[vict_idx]) begin
            state_d = ST_WBACK;
          end else begin
            vld_d[vict_idx] = 1'b0;
            state_d = ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = tag_q[vict_q];
        if (mem_ready) begin
          dty_d[vict_q] = 1'b0;
          vld_d[vict_q] = 1'b0;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          vld_d[vict_q] = 1'b1;
          dty_d[vict_q] = 1'b0;
          tag_d[vict_q] = req_tag;
          dat_d[vict_q] = mem_rline;
          state_d = ST_LOOKUP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= ST_IDLE;
      vict_q   <= '0;
      missed_q <= 1'b0;
      vld_q    <= '0;
      dty_q    <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        dat_q[i]  <= '0;
        rank_q[i] <= IDX_W'(i);
      end
    end else begin
      state_q  <= state_d;
      vict_q   <= vict_d;
      missed_q <= missed_d;
      vld_q    <= vld_d;
      dty_q    <= dty_d;
      tag_q    <= tag_d;
      dat_q    <= dat_d;
      rank_q   <= rank_d;
    end
  end

  wbc_sat_counter #(.W(CNT_W)) u_hits (
    .clk (clk), .rst_n (rst_int_n), .inc (inc_hit), .cnt (hit_cnt)
  );

  wbc_sat_counter #(.W(CNT_W)) u_misses (
    .clk (clk), .rst_n (rst_int_n), .inc (inc_miss), .cnt (miss_cnt)
  );
endmodule

// File: rtl/wbwa_cache_chk.sv
module wbwa_cache_chk #(
  parameter int TAG_W = 3,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_ready,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic             mem_we,
  input logic [TAG_W-1:0] mem_addr,
  input logic [CNT_W-1:0] hit_cnt,
  input logic [CNT_W-1:0] miss_cnt
);
  // R2
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  // R3
  fill_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && mem_ready) |=> cpu_ready);

  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && mem_ready) |=> (mem_valid && !mem_we));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr)));

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !cpu_ready);

  // R10
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |=> ($stable(hit_cnt) && $stable(miss_cnt)));

  // R10
  cnt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !((hit_cnt != $past(hit_cnt)) && (miss_cnt != $past(miss_cnt))));
endmodule

bind wbwa_cache wbwa_cache_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .hit_cnt   (hit_cnt),
  .miss_cnt  (miss_cnt)
);

// File: tb/wbwa_cache_tb.sv
module wbwa_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW    = 4;
  localparam int NTAG  = 8;
  localparam int NLINE = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_valid, cpu_ready, cpu_we;
  logic [3:0]  cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        mem_valid, mem_ready, mem_we;
  logic [2:0]  mem_addr;
  logic [15:0] mem_wline, mem_rline;
  logic [CW-1:0] hit_cnt, miss_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbwa_cache #(.CNT_W(CW)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .cpu_valid (cpu_valid), .cpu_ready (cpu_ready), .cpu_we (cpu_we),
    .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata),
    .mem_valid (mem_valid), .mem_ready (mem_ready), .mem_we (mem_we),
    .mem_addr (mem_addr), .mem_wline (mem_wline), .mem_rline (mem_rline),
    .hit_cnt (hit_cnt), .miss_cnt (miss_cnt)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference
  logic [7:0] mem_img [16];
  logic [7:0] m_data  [NTAG][2];
  bit         m_res   [NTAG];
  bit         m_dirty [NTAG];
  int         lru_q [$];
  int         exp_hit = 0, exp_miss = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    mem_ready = 1'b0;
    chk(hit_cnt == CW'(exp_hit), "R10", "hit_cnt", hit_cnt, exp_hit);
    chk(miss_cnt == CW'(exp_miss), "R10", "miss_cnt", miss_cnt, exp_miss);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      step();
      cpu_valid = 1'b0;
      chk(!cpu_ready && !mem_valid, "R9", "idle outputs", {cpu_ready, mem_valid}, 0);
    end
  endtask

  task automatic access(input bit we, input int addr, input int wd,
                        input int lat_wb, input int lat_fill);
    int  tg  = addr / 2;
    int  off = addr % 2;
    bit  hit = m_res[tg];
    step();
    chk(!cpu_ready && !mem_valid, "R1", "idle before request", {cpu_ready, mem_valid}, 0);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = 4'(addr); cpu_wdata = 8'(wd);
    if (!hit) begin
      step();
      chk(!cpu_ready && !mem_valid, "R9", "lookup miss stalls", {cpu_ready, mem_valid}, 0);
      if (lru_q.size() == NLINE) begin
        int v = lru_q[$];
        if (m_dirty[v]) begin
          for (int k = 0; k <= lat_wb; k++) begin
            step();
            chk(mem_valid && mem_we, "R6", "write-back request", {mem_valid, mem_we}, 3);
            chk(mem_addr == 3'(v), "R8", "victim tag", mem_addr, v);
            chk(mem_wline == {m_data[v][1], m_data[v][0]}, "R6", "write-back data",
                mem_wline, {m_data[v][1], m_data[v][0]});
            chk(!cpu_ready, "R9", "stall in write-back", cpu_ready, 0);
            if (k == lat_wb) begin
              mem_ready = 1'b1;
              mem_img[2*v]   = mem_wline[7:0];
              mem_img[2*v+1] = mem_wline[15:8];
            end
          end
        end
        m_res[v] = 1'b0;
        void'(lru_q.pop_back());
      end
      for (int k = 0; k <= lat_fill; k++) begin
        step();
        chk(mem_valid && !mem_we, "R7", "fill request is a read", {mem_valid, mem_we}, 2);
        chk(mem_addr == 3'(tg), "R3", "fill tag", mem_addr, tg);
        chk(!cpu_ready, "R9", "stall in fill", cpu_ready, 0);
        if (k == lat_fill) begin
          mem_ready = 1'b1;
          mem_rline = {mem_img[2*tg+1], mem_img[2*tg]};
        end
      end
      m_res[tg] = 1'b1; m_dirty[tg] = 1'b0;
      m_data[tg][0] = mem_img[2*tg]; m_data[tg][1] = mem_img[2*tg+1];
    end
    step();
    chk(cpu_ready && !mem_valid, hit ? "R2" : "R3", "completion", {cpu_ready, mem_valid}, 2);
    if (!we) chk(cpu_rdata == m_data[tg][off], hit ? "R2" : "R5", "load data",
                 cpu_rdata, m_data[tg][off]);
    else begin
      m_data[tg][off] = 8'(wd);
      m_dirty[tg] = 1'b1;
    end
    foreach (lru_q[i]) if (lru_q[i] == tg) begin lru_q.delete(i); break; end
    lru_q.push_front(tg);
    if (hit) begin if (exp_hit < (1 << CW) - 1) exp_hit++; end
    else begin if (exp_miss < (1 << CW) - 1) exp_miss++; end
  endtask

  initial begin
    rst_n = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    mem_ready = 1'b0; mem_rline = '0;
    for (int i = 0; i < 16; i++) mem_img[i] = 8'(8'h30 + 7 * i);
    for (int i = 0; i < NTAG; i++) begin m_res[i] = 0; m_dirty[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1: counters at zero, ports quiet (checked in idle), first access misses
    chk(hit_cnt == 0 && miss_cnt == 0, "R1", "counters after reset", {hit_cnt, miss_cnt}, 0);
    access(0, 1, 0, 0, 2);      // R3 R8: miss into free line
    access(0, 0, 0, 0, 0);      // R2: hit, other word
    access(0, 5, 0, 0, 1);      // R8: second free line
    access(1, 5, 8'hA5, 0, 0);  // R4: store hit, no traffic
    idle(2);
    access(0, 1, 0, 0, 0);      // tag0 most recent
    access(0, 10, 0, 3, 1);     // R6 R8: dirty tag2 written back first
    access(0, 5, 0, 0, 0);      // R7: clean tag0 dropped; R4 stored byte returns
    access(1, 12, 8'h5C, 0, 2); // R5: store miss allocates
    access(0, 13, 0, 0, 0);     // R5: other word from memory
    access(0, 12, 0, 0, 0);     // R5: merged byte
    access(0, 3, 0, 2, 0);      // R11: refilled tag2 evicted clean
    access(1, 7, 8'h77, 1, 0);  // R6: dirty tag6 written back
    for (int i = 0; i < 20; i++) access(0, 7, 0, 0, 0);          // R10 hit saturation
    for (int i = 0; i < 20; i++) access(i % 3 == 0, (i * 5) % 16, i, 0, i % 2); // R10 miss saturation
    idle(2);
    chk(hit_cnt == '1 && miss_cnt == '1, "R10", "both counters saturated",
        {hit_cnt, miss_cnt}, {CW{2'b11}});
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule